// File: doc/BRIEF.md
# APB Down-Counting Timer

This block is a 32-bit down-counting timer reached over an APB slave port. Software programs a reload value and a current count, sets an enable bit, and the counter steps down by one on every clock. In periodic use the count is refilled from the reload register once it has reached zero; when the reload register holds zero the timer runs once, signals, and then rests at zero with its enable bit still set until software gives it a new nonzero count.

A single sticky status bit records each genuine step of the count from one to zero. Software writes of zero to the count or reload registers, and enabling a timer whose count is already zero, never set it. The status bit is cleared by writing a one to it, and the interrupt line is the status bit gated by an interrupt-enable bit in the control register.

Top module: `apb_down_timer`

## Requirements
- R1: Reset (synchronous, active high) clears control, count, reload and status to zero and holds the interrupt line low.
- R2: Word offsets are decoded from address bits 3:2: 0x0 control, 0x4 current count, 0x8 reload, 0xC status. Control stores only write-data bits 3:0 and reads back zero above them; status reads back in bit 0 with zeros above.
- R3: While control bit 0 (run enable) is set and no count or reload write happens in the cycle, a count greater than one decreases by exactly one per clock.
- R4: A write to the reload register loads the written value into both the reload register and the current count.
- R5: The status bit becomes set at the same clock edge at which the count steps from one to zero.
- R6: Writing zero to the count or reload register, or enabling the timer while the count is zero, never sets the status bit.
- R7: With run enable set and a nonzero reload, a count of zero is replaced by the reload value at the next clock (no wrap to all ones).
- R8: With a zero reload, the count reaches zero, signals once and then stays at zero while run enable stays set.
- R9: With run enable set, a nonzero write to the count or reload register restarts counting, including after a one-shot has expired.
- R10: Writing the status register with bit 0 set clears the status bit; writing it with bit 0 clear has no effect; a one-to-zero step in the same cycle as a clear leaves the bit set.
- R11: The interrupt output equals the status bit ANDed with control bit 3 (interrupt enable).
- R12: A software write to the count or reload register takes priority over the clock's count step in the same cycle.
- R13: With run enable clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high, read when low |
| paddr | input | 4 | APB byte address, bits 3:2 pick the register |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data for the addressed register |
| irq | output | 1 | Interrupt request, level |

## Verification
The properties assume a well-formed APB master: penable is raised only in the cycle after a setup cycle with psel high, addresses are word aligned, and a write commits in exactly one access cycle. The bench drives every transfer through tasks that produce a setup cycle followed by a single access cycle and then return to idle, so no property sees a malformed transfer. Write data is biased toward zero, one and small counts so that expiries, one-shot holds and clears colliding with a one-to-zero step occur often.

// File: rtl/apb_down_timer_pkg.sv
package apb_down_timer_pkg;

    localparam int ADDR_W = 4;
    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       irq_en;
        logic [1:0] spare;
        logic       run_en;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_count;
        logic wr_reload;
        logic wr_status;
    } wr_strobe_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        return reg_sel_e'(addr[3:2]);
    endfunction

endpackage

// File: rtl/apb_down_timer_regs.sv
module apb_down_timer_regs
    import apb_down_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] count,
    input  logic              status,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] reload,
    output wr_strobe_t        wr,
    output logic [DATA_W-1:0] prdata
);

    localparam int CTRL_PAD   = DATA_W - CTRL_W;
    localparam int STATUS_PAD = DATA_W - 1;

    reg_sel_e sel;
    logic     wr_access;

    assign sel       = decode_sel(paddr);
    assign wr_access = psel & penable & pwrite;

    always_comb begin
        wr           = '0;
        wr.wr_ctrl   = wr_access && (sel == SEL_CTRL);
        wr.wr_count  = wr_access && (sel == SEL_COUNT);
        wr.wr_reload = wr_access && (sel == SEL_RELOAD);
        wr.wr_status = wr_access && (sel == SEL_STATUS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr.wr_ctrl) begin
            ctrl <= ctrl_t'(pwdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else if (wr.wr_reload) begin
            reload <= pwdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:   prdata = {{CTRL_PAD{1'b0}}, ctrl};
            SEL_COUNT:  prdata = count;
            SEL_RELOAD: prdata = reload;
            SEL_STATUS: prdata = {{STATUS_PAD{1'b0}}, status};
            default:    prdata = '0;
        endcase
    end

endmodule

// File: rtl/apb_down_timer_counter.sv
module apb_down_timer_counter
    import apb_down_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  wr_strobe_t        wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] count,
    output logic              fire
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] count_d;
    logic              sw_load;

    assign sw_load = wr.wr_count | wr.wr_reload;

    // Software loads win over the step; only a real 1 -> 0 step fires.
    always_comb begin
        count_d = count;
        fire    = 1'b0;
        if (sw_load) begin
            count_d = wdata;
        end else if (run_en) begin
            if (count == ONE) begin
                count_d = '0;
                fire    = 1'b1;
            end else if (count == '0) begin
                if (reload != '0) begin
                    count_d = reload;
                end
            end else begin
                count_d = count - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count_d;
        end
    end

endmodule

// File: rtl/apb_down_timer_irq.sv
module apb_down_timer_irq (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic irq_en,
    output logic status,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (fire) begin
            status <= 1'b1;
        end else if (clr_wr && clr_bit) begin
            status <= 1'b0;
        end
    end

    assign irq = status & irq_en;

endmodule

// File: rtl/apb_down_timer.sv
module apb_down_timer
    import apb_down_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);

    ctrl_t             ctrl_q;
    wr_strobe_t        wr_s;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic              status_q;
    logic              fire_s;

    apb_down_timer_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .count   (count_q),
        .status  (status_q),
        .ctrl    (ctrl_q),
        .reload  (reload_q),
        .wr      (wr_s),
        .prdata  (prdata)
    );

    apb_down_timer_counter #(.DATA_W(DATA_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .run_en (ctrl_q.run_en),
        .wr     (wr_s),
        .wdata  (pwdata),
        .reload (reload_q),
        .count  (count_q),
        .fire   (fire_s)
    );

    apb_down_timer_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire_s),
        .clr_wr  (wr_s.wr_status),
        .clr_bit (pwdata[0]),
        .irq_en  (ctrl_q.irq_en),
        .status  (status_q),
        .irq     (irq)
    );

endmodule

// File: rtl/apb_down_timer_chk.sv
module apb_down_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [3:0]        paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload,
    input logic              status,
    input logic              run_en
);

    logic acc_w, w_cnt, w_st;
    assign acc_w = psel && penable && pwrite;
    assign w_cnt = acc_w && (paddr[3:2] == 2'd1 || paddr[3:2] == 2'd2);
    assign w_st  = acc_w && (paddr[3:2] == 2'd3);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && reload == '0 && !status));

    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (run_en && !w_cnt && count > DATA_W'(1)) |=> (count == $past(count) - DATA_W'(1)));

    p_fire_r5: assert property (@(posedge clk) disable iff (rst)
        (run_en && !w_cnt && count == DATA_W'(1)) |=> (status && count == '0));

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        (!status && !(run_en && !w_cnt && count == DATA_W'(1))) |=> !status);

    p_refill_r7: assert property (@(posedge clk) disable iff (rst)
        (run_en && !w_cnt && count == '0 && reload != '0) |=> (count == $past(reload)));

    p_oneshot_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (run_en && !w_cnt && count == '0 && reload == '0) |=> (count == '0));

    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
        (w_st && pwdata[0] && !(run_en && !w_cnt && count == DATA_W'(1))) |=> !status);

    p_sw_load_r12: assert property (@(posedge clk) disable iff (rst)
        w_cnt |=> (count == $past(pwdata)));

    p_hold_off_r13: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !w_cnt) |=> $stable(count));

endmodule

bind apb_down_timer apb_down_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .count   (count_q),
    .reload  (reload_q),
    .status  (status_q),
    .run_en  (ctrl_q.run_en)
);

// File: tb/apb_down_timer_test.sv
module apb_down_timer_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]   paddr = '0;
    logic [W-1:0] pwdata = '0;
    logic [W-1:0] prdata;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    apb_down_timer #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
    );

    // Reference model built from the requirements
    logic [3:0]   m_ctrl;
    logic [W-1:0] m_cnt, m_rel;
    logic         m_st;

    function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic [W-1:0] r,
                                                input logic en);
        if (!en)        return c;            // R13
        if (c == 1)     return '0;           // R5
        if (c == 0)     return (r != 0) ? r : '0; // R7 / R8
        return c - 1;                        // R3
    endfunction

    function automatic logic [W-1:0] exp_read(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return {28'd0, m_ctrl};
            2'd1:    return m_cnt;
            2'd2:    return m_rel;
            default: return {31'd0, m_st};
        endcase
    endfunction

    always @(posedge clk) begin
        logic acc, wc, wr_, fire;
        logic [W-1:0] n_cnt;
        if (rst) begin
            m_ctrl = '0; m_cnt = '0; m_rel = '0; m_st = 1'b0;
        end else begin
            acc  = psel && penable && pwrite;
            wc   = acc && paddr[3:2] == 2'd1;
            wr_  = acc && paddr[3:2] == 2'd2;
            fire = !(wc || wr_) && m_ctrl[0] && m_cnt == 1;
            n_cnt = (wc || wr_) ? pwdata : next_count(m_cnt, m_rel, m_ctrl[0]);
            if (fire) m_st = 1'b1;
            else if (acc && paddr[3:2] == 2'd3 && pwdata[0]) m_st = 1'b0;
            if (wr_) m_rel = pwdata;
            if (acc && paddr[3:2] == 2'd0) m_ctrl = pwdata[3:0];
            m_cnt = n_cnt;
        end
    end

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // R11: interrupt line sampled every cycle away from the edge
    always @(negedge clk) begin
        if (!rst && !done) check("R11 irq", {31'd0, irq}, {31'd0, m_st & m_ctrl[3]});
    end

    task automatic apb_write(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [3:0] a, input string tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check(tag, prdata, exp_read(a));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_lit(input logic [3:0] a, input logic [W-1:0] exp, input string tag);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check(tag, prdata, exp);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset values
        read_lit(4'h0, 32'd0, "R1 ctrl");
        read_lit(4'h4, 32'd0, "R1 count");
        read_lit(4'h8, 32'd0, "R1 reload");
        read_lit(4'hC, 32'd0, "R1 status");

        // R2: only the low four control bits are kept
        apb_write(4'h0, 32'hFFFF_FFF8);
        read_lit(4'h0, 32'h8, "R2 ctrl mask");
        apb_write(4'h0, 32'h9);
        read_lit(4'h0, 32'h9, "R2 ctrl");

        // R6: zero writes while enabled must not set status
        apb_write(4'h8, 32'd0);
        apb_write(4'h4, 32'd0);
        idle(5);
        read_lit(4'hC, 32'd0, "R6 zero writes");
        apb_write(4'h0, 32'h8);
        apb_write(4'h0, 32'h9);
        idle(3);
        read_lit(4'hC, 32'd0, "R6 enable at zero");

        // R4 / R3 / R5: reload write loads count, counts down, fires
        apb_write(4'h0, 32'h8);
        apb_write(4'h8, 32'd40);
        read_lit(4'h4, 32'd40, "R4 reload loads count");
        apb_write(4'h0, 32'h9);
        apb_read(4'h4, "R3 decrement");
        apb_read(4'h4, "R3 decrement again");
        idle(40);
        read_lit(4'hC, 32'd1, "R5 status set");
        check("R11 irq high", {31'd0, irq}, 32'd1);

        // R10: write 0 keeps, write 1 clears
        apb_write(4'hC, 32'd0);
        apb_read(4'hC, "R10 write zero keeps");
        apb_write(4'hC, 32'd1);
        apb_read(4'hC, "R10 clear");

        // R7: periodic refill
        apb_write(4'h8, 32'd3);
        repeat (8) apb_read(4'h4, "R7 periodic");

        // R8: one-shot, holds at zero with enable still set
        apb_write(4'h8, 32'd0);
        apb_write(4'hC, 32'd1);
        apb_write(4'h4, 32'd2);
        idle(10);
        read_lit(4'h4, 32'd0, "R8 held at zero");
        read_lit(4'hC, 32'd1, "R8 fired once");
        read_lit(4'h0, 32'h9, "R8 enable kept");
        apb_write(4'hC, 32'd1);
        idle(10);
        read_lit(4'hC, 32'd0, "R8 no refire");

        // R9: nonzero value write after expiry resumes counting
        apb_write(4'h4, 32'd30);
        apb_read(4'h4, "R9 resume");
        idle(4);
        apb_read(4'h4, "R9 resume counting");
        apb_write(4'h8, 32'd25);
        apb_read(4'h4, "R9 reload resume");

        // R12: write during counting overrides the step
        apb_write(4'h4, 32'd100);
        apb_read(4'h4, "R12 write wins");

        // R13: disabled holds
        apb_write(4'h0, 32'h8);
        apb_write(4'h4, 32'd6);
        idle(10);
        read_lit(4'h4, 32'd6, "R13 hold");

        // Random phase, biased toward small counts
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [W-1:0] d;
            op = $urandom % 10;
            d  = ($urandom % 4 != 0) ? W'($urandom % 5) : W'($urandom % 30);
            case (op)
                0:       apb_write(4'h0, W'($urandom % 16));
                1:       apb_write(4'h4, d);
                2:       apb_write(4'h8, d);
                3:       apb_write(4'hC, W'($urandom % 2));
                4, 5:    apb_read(4'h4, "R3 random count");
                6:       apb_read(4'hC, "R5 random status");
                7:       apb_read(4'h8, "R2 random reload");
                default: idle($urandom % 6);
            endcase
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule